// File: doc/BRIEF.md
# CPU Clock Power-Mode Controller

This block decides where the CPU clock and the two bus clocks come from, and whether they run at all. It has three modes. In run mode the CPU clock is taken from the PLL and the two bus clocks are integer divisions of that rate. In direct-run mode all three clocks come straight from the system reference clock, undivided. In halt mode the reference clock is gated off, and the CPU and bus clocks stop. Only wake logic on the always-on side keeps working in halt.

Software moves the block between modes with a run-select level and a one-cycle stop request. Halt can only be entered from direct-run, and a wake event always leaves halt into direct-run. A run to halt trip, or a halt to run trip, therefore always passes through direct-run. Run entry waits until the PLL reports lock. The PLL control word can be rewritten only while the block is in direct-run, which is the mode in which no clock depends on the PLL. The outputs are the mode status, the clock-source select, the gate enables and the bus divisor selections. The clock mux cells, the gates and the PLL itself sit outside this block. All inputs are taken as already synchronous to `clk`.

Top module: `pwr_clkmode_ctrl`

## Requirements
- R1: After reset, `mode` is direct-run (2'b01), `stop_pending` is 0 and `pll_cfg` is 0.
- R2: The mode status encodes run as 2'b10, direct-run as 2'b01 and halt as 2'b00. The clock outputs follow the registered mode:
  - In run: `clk_sel_pll`=1, all enables are 1, `hbus_div`=HBUS_DIV (2) and `pbus_div`=PBUS_DIV (4).
  - In direct-run: `clk_sel_pll`=0, all enables are 1, and both divisors are 1.
  - In halt: `clk_sel_pll`=0, all enables are 0, and both divisors are 1.
- R3: In direct-run, the block moves to run on the next edge when `run_sel`=1, `pll_lock`=1, `stop_pending`=0 and no enabled wake event is present. While `pll_lock`=0 it stays in direct-run.
- R4: In run, `run_sel`=0 returns the block to direct-run on the next edge. Otherwise it stays in run, even when a stop is pending. Run never goes straight to halt.
- R5: In direct-run, the block moves to halt on the next edge when `stop_pending`=1 and no enabled wake event is present. Halt takes priority over a run request.
- R6: An enabled wake event is any bit i with `wake_evt[i]`=1 and `wake_en[i]`=1. In halt, such an event returns the block to direct-run on the next edge, even when `run_sel`=1. An event with its enable bit at 0 is ignored.
- R7: A `stop_req` pulse sets `stop_pending` on the next edge. Any enabled wake event clears it on the next edge and takes priority over a new request. A wake seen in direct-run while a stop is pending therefore aborts halt entry.
- R8: A `pll_wr` pulse loads `pll_wdata` into `pll_cfg` on the next edge only in direct-run. Writes in run or halt leave `pll_cfg` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (always-on domain) |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_sel | input | 1 | Level: 1 requests run mode |
| stop_req | input | 1 | One-cycle pulse requesting halt |
| pll_lock | input | 1 | PLL lock status |
| wake_evt | input | N_WAKE | Wake event lines |
| wake_en | input | N_WAKE | Per-line wake enables |
| pll_wr | input | 1 | PLL control write strobe |
| pll_wdata | input | PLL_W | PLL control write data |
| mode | output | 2 | Mode status: 10 run, 01 direct-run, 00 halt |
| stop_pending | output | 1 | Stop request awaiting halt entry |
| clk_sel_pll | output | 1 | 1 selects the PLL as clock source |
| ref_clk_en | output | 1 | Reference clock gate enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| bus_clk_en | output | 1 | Bus clock gate enable |
| hbus_div | output | DIV_W | Fast bus divisor |
| pbus_div | output | DIV_W | Peripheral bus divisor |
| pll_cfg | output | PLL_W | PLL control word |

## Verification
The bench runs a near-exhaustive pseudo-random sweep of several thousand cycles. Each cycle it draws a run level, a lock value, stop pulses, wake lines and enables, and PLL writes. It compares every output against a mode model built from the requirements. Directed sequences then cover the corners. Lock-low holds off run entry, which separates the lock gating from plain run selection. A stop and a wake in the same cycle show that the wake has priority. A masked wake during halt separates masking from detection. PLL writes made in each mode show that only direct-run accepts them.

// File: rtl/pwrmode_pkg.sv
package pwrmode_pkg;
  typedef enum logic [1:0] {
    MODE_HALT   = 2'b00,
    MODE_DIRECT = 2'b01,
    MODE_RUN    = 2'b10
  } pwr_mode_t;
endpackage

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect #(
  parameter int N_WAKE = 3
) (
  input  logic [N_WAKE-1:0] wake_evt,
  input  logic [N_WAKE-1:0] wake_en,
  output logic              wake_hit
);
  logic [N_WAKE-1:0] qual;
  for (genvar i = 0; i < N_WAKE; i++) begin : g_qual
    assign qual[i] = wake_evt[i] & wake_en[i];
  end
  assign wake_hit = |qual;
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwrmode_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run_sel,
  input  logic      pll_lock,
  input  logic      stop_req,
  input  logic      wake_hit,
  output pwr_mode_t mode_q,
  output logic      stop_pend_q
);
  pwr_mode_t mode_d;
  logic      stop_pend_d;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_RUN:    if (!run_sel) mode_d = MODE_DIRECT;
      MODE_DIRECT: begin
        if (stop_pend_q && !wake_hit)                            mode_d = MODE_HALT;
        else if (run_sel && pll_lock && !stop_pend_q && !wake_hit) mode_d = MODE_RUN;
      end
      MODE_HALT:   if (wake_hit) mode_d = MODE_DIRECT;
      default:     mode_d = MODE_DIRECT;
    endcase
  end

  always_comb begin
    stop_pend_d = stop_pend_q;
    if (wake_hit)      stop_pend_d = 1'b0;
    else if (stop_req) stop_pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= MODE_DIRECT;
      stop_pend_q <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      stop_pend_q <= stop_pend_d;
    end
  end

  // R4: run never steps straight into halt
  p_run_not_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == MODE_RUN |=> mode_q != MODE_HALT);
  // R6: halt never steps straight into run
  p_halt_not_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == MODE_HALT |=> mode_q != MODE_RUN);
  // R3: run entry needs PLL lock
  p_lock_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_DIRECT && !pll_lock) |=> mode_q != MODE_RUN);
  // R6/R7: wake in halt leaves to direct-run with stop cleared
  p_wake_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_HALT && wake_hit) |=> (mode_q == MODE_DIRECT && !stop_pend_q));
  // R5: halt only entered from direct-run with a stop pending
  p_halt_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_HALT) ##1 (mode_q == MODE_HALT) |->
      ($past(mode_q) == MODE_DIRECT && $past(stop_pend_q)));
endmodule

// File: rtl/pwr_pll_cfg.sv
module pwr_pll_cfg
  import pwrmode_pkg::*;
#(
  parameter int PLL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pwr_mode_t        mode,
  input  logic             pll_wr,
  input  logic [PLL_W-1:0] pll_wdata,
  output logic [PLL_W-1:0] pll_cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              pll_cfg <= '0;
    else if (pll_wr && mode == MODE_DIRECT)  pll_cfg <= pll_wdata;
  end

  // R8: PLL word frozen outside direct-run
  p_pll_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode != MODE_DIRECT |=> $stable(pll_cfg));
endmodule

// File: rtl/pwr_clk_route.sv
module pwr_clk_route
  import pwrmode_pkg::*;
#(
  parameter int DIV_W    = 4,
  parameter int HBUS_DIV = 2,
  parameter int PBUS_DIV = 4
) (
  input  pwr_mode_t        mode,
  output logic             clk_sel_pll,
  output logic             ref_clk_en,
  output logic             cpu_clk_en,
  output logic             bus_clk_en,
  output logic [DIV_W-1:0] hbus_div,
  output logic [DIV_W-1:0] pbus_div
);
  localparam logic [DIV_W-1:0] HDIV = DIV_W'(HBUS_DIV);
  localparam logic [DIV_W-1:0] PDIV = DIV_W'(PBUS_DIV);
  localparam logic [DIV_W-1:0] ONE  = DIV_W'(1);

  logic running, on_pll;
  assign on_pll      = (mode == MODE_RUN);
  assign running     = (mode != MODE_HALT);
  assign clk_sel_pll = on_pll;
  assign ref_clk_en  = running;
  assign cpu_clk_en  = running;
  assign bus_clk_en  = running;
  assign hbus_div    = on_pll ? HDIV : ONE;
  assign pbus_div    = on_pll ? PDIV : ONE;

  // R2: gating and source never conflict
  always_comb begin
    a_gate_src_r2: assert (!(clk_sel_pll && !cpu_clk_en));
  end
endmodule

// File: rtl/pwr_clkmode_ctrl.sv
module pwr_clkmode_ctrl
  import pwrmode_pkg::*;
#(
  parameter int N_WAKE   = 3,
  parameter int PLL_W    = 8,
  parameter int DIV_W    = 4,
  parameter int HBUS_DIV = 2,
  parameter int PBUS_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_sel,
  input  logic              stop_req,
  input  logic              pll_lock,
  input  logic [N_WAKE-1:0] wake_evt,
  input  logic [N_WAKE-1:0] wake_en,
  input  logic              pll_wr,
  input  logic [PLL_W-1:0]  pll_wdata,
  output logic [1:0]        mode,
  output logic              stop_pending,
  output logic              clk_sel_pll,
  output logic              ref_clk_en,
  output logic              cpu_clk_en,
  output logic              bus_clk_en,
  output logic [DIV_W-1:0]  hbus_div,
  output logic [DIV_W-1:0]  pbus_div,
  output logic [PLL_W-1:0]  pll_cfg
);
  logic      wake_hit;
  pwr_mode_t mode_q;

  pwr_wake_detect #(.N_WAKE(N_WAKE)) u_wake (
    .wake_evt(wake_evt), .wake_en(wake_en), .wake_hit(wake_hit));

  pwr_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .run_sel(run_sel), .pll_lock(pll_lock),
    .stop_req(stop_req), .wake_hit(wake_hit),
    .mode_q(mode_q), .stop_pend_q(stop_pending));

  pwr_pll_cfg #(.PLL_W(PLL_W)) u_pll (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .pll_wr(pll_wr),
    .pll_wdata(pll_wdata), .pll_cfg(pll_cfg));

  pwr_clk_route #(.DIV_W(DIV_W), .HBUS_DIV(HBUS_DIV), .PBUS_DIV(PBUS_DIV)) u_route (
    .mode(mode_q), .clk_sel_pll(clk_sel_pll), .ref_clk_en(ref_clk_en),
    .cpu_clk_en(cpu_clk_en), .bus_clk_en(bus_clk_en),
    .hbus_div(hbus_div), .pbus_div(pbus_div));

  assign mode = mode_q;

  // R2: halt means every gate closed
  p_halt_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b00 |-> (!ref_clk_en && !cpu_clk_en && !bus_clk_en));
endmodule

// File: tb/test_pwr_clkmode_ctrl.sv
module test_pwr_clkmode_ctrl;
  localparam int NW = 3, PW = 8, DW = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic run_sel = 0, stop_req = 0, pll_lock = 0, pll_wr = 0;
  logic [NW-1:0] wake_evt = '0, wake_en = '0;
  logic [PW-1:0] pll_wdata = '0;
  logic [1:0] mode;
  logic stop_pending, clk_sel_pll, ref_clk_en, cpu_clk_en, bus_clk_en;
  logic [DW-1:0] hbus_div, pbus_div;
  logic [PW-1:0] pll_cfg;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [1:0] e_mode;
  logic e_pend;
  logic [PW-1:0] e_cfg;

  always #10 clk = ~clk;

  pwr_clkmode_ctrl i_pwr_clkmode_ctrl (
    .clk(clk), .rst_n(rst_n), .run_sel(run_sel), .stop_req(stop_req),
    .pll_lock(pll_lock), .wake_evt(wake_evt), .wake_en(wake_en),
    .pll_wr(pll_wr), .pll_wdata(pll_wdata), .mode(mode),
    .stop_pending(stop_pending), .clk_sel_pll(clk_sel_pll),
    .ref_clk_en(ref_clk_en), .cpu_clk_en(cpu_clk_en), .bus_clk_en(bus_clk_en),
    .hbus_div(hbus_div), .pbus_div(pbus_div), .pll_cfg(pll_cfg));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // expected outputs derived from R2
  task automatic chk_outputs();
    bit r = (e_mode == 2'b10), h = (e_mode == 2'b00);
    chk("R2 mode", mode, e_mode);
    chk("R2 sel", clk_sel_pll, r);
    chk("R2 gates", {ref_clk_en, cpu_clk_en, bus_clk_en}, h ? 0 : 7);
    chk("R2 hdiv", hbus_div, r ? 2 : 1);
    chk("R2 pdiv", pbus_div, r ? 4 : 1);
  endtask

  // reference model step, computed from R3..R8; then advance one clock
  task automatic step(input string tag_unused);
    bit wk = |(wake_evt & wake_en);
    logic [1:0] nm = e_mode;
    string tag;
    case (e_mode)
      2'b10: begin tag = "R4"; if (!run_sel) nm = 2'b01; end
      2'b00: begin tag = "R6"; if (wk) nm = 2'b01; end
      default: begin
        tag = "R3";
        if (e_pend && !wk) begin nm = 2'b00; tag = "R5"; end
        else if (run_sel && pll_lock && !e_pend && !wk) nm = 2'b10;
      end
    endcase
    if (pll_wr && e_mode == 2'b01) e_cfg = pll_wdata;
    if (wk) e_pend = 0; else if (stop_req) e_pend = 1;
    e_mode = nm;
    @(negedge clk);
    chk(tag, mode, e_mode);
    chk("R7 pend", stop_pending, e_pend);
    chk("R8 cfg", pll_cfg, e_cfg);
    chk_outputs();
    stop_req = 0; pll_wr = 0;
  endtask

  initial begin
    #3000000;
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    e_mode = 2'b01; e_pend = 0; e_cfg = '0;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1 mode", mode, 2'b01);
    chk("R1 pend", stop_pending, 0);
    chk("R1 cfg", pll_cfg, 0);
    rst_n = 1;
    @(negedge clk);
    // R3: lock low holds off run
    run_sel = 1; pll_lock = 0; step("");
    chk("R3 held", mode, 2'b01);
    // R8: write in direct taken
    pll_wr = 1; pll_wdata = 8'h5A; step("");
    chk("R8 direct write", pll_cfg, 8'h5A);
    pll_lock = 1; step("");
    chk("R3 run", mode, 2'b10);
    // R8: write in run ignored
    pll_wr = 1; pll_wdata = 8'hC3; step("");
    chk("R8 run write ignored", pll_cfg, 8'h5A);
    // R4: stop pending keeps run
    stop_req = 1; step(""); step("");
    chk("R4 stays run", mode, 2'b10);
    run_sel = 0; step("");
    chk("R4 to direct", mode, 2'b01);
    step("");
    chk("R5 halt", mode, 2'b00);
    // R6: masked wake ignored; R8 write in halt ignored
    run_sel = 1; wake_evt = 3'b010; wake_en = 3'b101; pll_wr = 1; pll_wdata = 8'h11; step("");
    chk("R6 masked", mode, 2'b00);
    chk("R8 halt write ignored", pll_cfg, 8'h5A);
    wake_en = 3'b010; step("");
    chk("R6 wake to direct", mode, 2'b01);
    chk("R7 cleared", stop_pending, 0);
    wake_evt = 0; run_sel = 0; step("");
    // R7: stop+wake same cycle: wake wins; later wake aborts halt
    stop_req = 1; wake_evt = 3'b010; step("");
    chk("R7 wake priority", stop_pending, 0);
    wake_evt = 0; stop_req = 1; step("");
    wake_evt = 3'b010; step("");
    chk("R7 abort", mode, 2'b01);
    wake_evt = 0;
    // near-exhaustive sweep
    for (int i = 0; i < 6000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      run_sel  = lfsr[0] | lfsr[5];
      pll_lock = |lfsr[3:1];
      stop_req = (lfsr[9:7] == 3'd0);
      wake_evt = (lfsr[12:10] == 3'd5) ? lfsr[15:13] : '0;
      wake_en  = lfsr[6:4];
      pll_wr   = lfsr[11];
      pll_wdata = lfsr[7:0] ^ lfsr[15:8];
      step("");
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule